// File: doc/BRIEF.md
# Watchdog Timer with Two-Key Clear

This block is a supervisory timer for a small processor core. It counts strobes from one of three clock sources. The sources are a local slow oscillator, the instruction-rate clock and a real-time-clock tick, and each reaches the block as a single-cycle enable strobe. The strobes first pass through a 3-bit prescaler and then an 8-bit counter. When the counter runs past its top value, the block has timed out. It then sets a time-out flag. If the core is running, the block pulses a chip-reset output. If the core is halted, it pulses a wake-up output and does not reset the chip.

Software keeps the timer from expiring by issuing clear commands. These arrive as single-cycle strobes from the core. A static configuration input selects one of two clearing schemes. In the first scheme, one general clear command is enough. In the second, two distinct clear commands (key A and key B) must arrive in alternation before the timer is cleared. Every accepted clear empties the prescaler and the counter and drops both the time-out flag and the power-down flag. The power-down flag is set when the core enters its halted state.

Top module: `wdog_guard`

## Requirements
- R1: After reset, `wd_count` is 0, `to_flag` and `pdf_flag` are 0, and `chip_rst` and `wake` are 0.
- R2: `src_sel` chooses the counting strobe: 0 = off (nothing counts), 1 = `tick_local`, 2 = `tick_instr`, 3 = `tick_rtc`. Strobes on unselected sources have no effect on `wd_count`.
- R3: `wd_count` advances by one on every eighth accepted strobe, counting from a cleared state.
- R4: The 2048th accepted strobe after a clear, seen while `halted` is 0, makes `chip_rst` high for exactly one cycle in the following cycle. In that same cycle `to_flag` becomes 1 and `wd_count` returns to 0.
- R5: A time-out while `halted` is 1 pulses `wake` for one cycle and sets `to_flag`. It leaves `chip_rst` low and `pdf_flag` unchanged.
- R6: With `dual_key` = 0, a `clr_stb` pulse clears `wd_count`, the prescaler, `to_flag` and `pdf_flag` in the next cycle. `clr_a` and `clr_b` have no effect in this mode.
- R7: With `dual_key` = 1, a clear happens only when a `clr_a` follows a `clr_b`, or a `clr_b` follows a `clr_a`. `clr_stb` has no effect in this mode.
- R8: With `dual_key` = 1, repeating the same key (A then A, or B then B) does not clear.
- R9: After a two-key clear, the key history is forgotten, so a single further key never clears by itself.
- R10: A `halt_enter` pulse sets `pdf_flag` in the next cycle. A clear accepted in the same cycle takes priority, and `pdf_flag` then reads 0.
- R11: A clear that arrives in the same cycle as a counting strobe takes priority. The strobe is lost, and eight more strobes are needed to reach a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_sel | input | 2 | Counting source select (0 off, 1 local, 2 instruction, 3 rtc) |
| tick_local | input | 1 | Enable strobe from the local oscillator |
| tick_instr | input | 1 | Enable strobe at the instruction rate |
| tick_rtc | input | 1 | Enable strobe from the real-time clock |
| dual_key | input | 1 | 0 = single-command clear, 1 = two-key alternating clear |
| clr_stb | input | 1 | General clear command strobe |
| clr_a | input | 1 | Clear key A strobe |
| clr_b | input | 1 | Clear key B strobe |
| halted | input | 1 | Core is in its halted state |
| halt_enter | input | 1 | Strobe when the core enters the halted state |
| chip_rst | output | 1 | One-cycle reset request on time-out while running |
| wake | output | 1 | One-cycle wake request on time-out while halted |
| to_flag | output | 1 | Time-out flag |
| pdf_flag | output | 1 | Power-down flag |
| wd_count | output | 8 | Current counter value |

## Verification
The bench targets the edge of the time-out. After 2047 strobes `chip_rst` must still be low, and it must be high after the 2048th. A design with an off-by-one prescaler, or one that ignores the halted state, shows up there as a reset one cycle late or a reset in place of a wake-up. In two-key mode, the bench sends repeated keys, the general strobe, and a lone key right after a completed pair. A design that matches on any key, or that keeps its key history across a clear, would clear when it should not. The bench also sends a clear together with a strobe when the count is at its limit. A design that lets the strobe through would show a reset or a count that is one higher than expected.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        SRC_OFF   = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_INSTR = 2'd2,
        SRC_RTC   = 2'd3
    } wd_src_e;

    typedef enum logic [1:0] {
        KEY_IDLE   = 2'd0,
        KEY_A_SEEN = 2'd1,
        KEY_B_SEEN = 2'd2
    } key_state_e;
endpackage

// File: rtl/wdog_tick_mux.sv
module wdog_tick_mux
    import wdog_pkg::*;
(
    input  logic [1:0] src_sel,
    input  logic       tick_local,
    input  logic       tick_instr,
    input  logic       tick_rtc,
    output logic       tick
);
    always_comb begin
        case (wd_src_e'(src_sel))
            SRC_LOCAL: tick = tick_local;
            SRC_INSTR: tick = tick_instr;
            SRC_RTC:   tick = tick_rtc;
            default:   tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/wdog_key_seq.sv
module wdog_key_seq
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic key_a,
    input  logic key_b,
    output logic unlock
);
    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unlock  = 1'b0;
        if (!enable) begin
            state_d = KEY_IDLE;
        end else if (key_a && !key_b) begin
            if (state_q == KEY_B_SEEN) begin
                unlock  = 1'b1;
                state_d = KEY_IDLE;
            end else begin
                state_d = KEY_A_SEEN;
            end
        end else if (key_b && !key_a) begin
            if (state_q == KEY_A_SEEN) begin
                unlock  = 1'b1;
                state_d = KEY_IDLE;
            end else begin
                state_d = KEY_B_SEEN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
    parameter int PRE_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic             tick_local,
    input  logic             tick_instr,
    input  logic             tick_rtc,
    input  logic             dual_key,
    input  logic             clr_stb,
    input  logic             clr_a,
    input  logic             clr_b,
    input  logic             halted,
    input  logic             halt_enter,
    output logic             chip_rst,
    output logic             wake,
    output logic             to_flag,
    output logic             pdf_flag,
    output logic [CNT_W-1:0] wd_count
);
    localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
        logic             to;
        logic             pdf;
        logic             rst_p;
        logic             wake_p;
    } wd_state_t;

    wd_state_t st_d, st_q;
    logic      tick;
    logic      key_unlock;
    logic      clear_go;

    wdog_tick_mux u_mux (
        .src_sel    (src_sel),
        .tick_local (tick_local),
        .tick_instr (tick_instr),
        .tick_rtc   (tick_rtc),
        .tick       (tick)
    );

    wdog_key_seq u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (dual_key),
        .key_a  (clr_a),
        .key_b  (clr_b),
        .unlock (key_unlock)
    );

    assign clear_go = dual_key ? key_unlock : clr_stb;

    always_comb begin
        st_d        = st_q;
        st_d.rst_p  = 1'b0;
        st_d.wake_p = 1'b0;
        if (clear_go) begin
            st_d.pre = '0;
            st_d.cnt = '0;
            st_d.to  = 1'b0;
            st_d.pdf = 1'b0;
        end else begin
            if (halt_enter) st_d.pdf = 1'b1;
            if (tick) begin
                if (st_q.pre == PRE_MAX) begin
                    st_d.pre = '0;
                    if (st_q.cnt == CNT_MAX) begin
                        st_d.cnt = '0;
                        st_d.to  = 1'b1;
                        if (halted) st_d.wake_p = 1'b1;
                        else        st_d.rst_p  = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end else begin
                    st_d.pre = st_q.pre + PRE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chip_rst = st_q.rst_p;
    assign wake     = st_q.wake_p;
    assign to_flag  = st_q.to;
    assign pdf_flag = st_q.pdf;
    assign wd_count = st_q.cnt;
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_sel,
    input logic             dual_key,
    input logic             clr_stb,
    input logic             clr_a,
    input logic             clr_b,
    input logic             halted,
    input logic             halt_enter,
    input logic             chip_rst,
    input logic             wake,
    input logic             to_flag,
    input logic             pdf_flag,
    input logic [CNT_W-1:0] wd_count
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (wd_count == '0 && !to_flag && !pdf_flag && !chip_rst && !wake));

    a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd0 && !clr_stb && !clr_a && !clr_b) |=> $stable(wd_count));

    a_r4_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |=> !chip_rst);

    a_r4_rst_sets_to: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> (to_flag && wd_count == '0));

    a_r4_rst_not_halted: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> !$past(halted));

    a_r5_wake_halted: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> ($past(halted) && to_flag && !chip_rst));

    a_r6_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_key && clr_stb) |=> (wd_count == '0 && !to_flag && !pdf_flag));

    a_r8_no_clear_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_key && clr_a && !clr_b && $past(clr_a) && !$past(clr_b) && $past(dual_key)
         && wd_count != '0 && src_sel == 2'd0) |=> (wd_count == $past(wd_count)));

    a_r10_pdf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_enter && !clr_stb && !clr_a && !clr_b) |=> pdf_flag);
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_sel    (src_sel),
    .dual_key   (dual_key),
    .clr_stb    (clr_stb),
    .clr_a      (clr_a),
    .clr_b      (clr_b),
    .halted     (halted),
    .halt_enter (halt_enter),
    .chip_rst   (chip_rst),
    .wake       (wake),
    .to_flag    (to_flag),
    .pdf_flag   (pdf_flag),
    .wd_count   (wd_count)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic       tick_local = 0, tick_instr = 0, tick_rtc = 0;
    logic       dual_key = 0, clr_stb = 0, clr_a = 0, clr_b = 0;
    logic       halted = 0, halt_enter = 0;
    logic       chip_rst, wake, to_flag, pdf_flag;
    logic [7:0] wd_count;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdog_guard i_wdog_guard (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel),
        .tick_local(tick_local), .tick_instr(tick_instr), .tick_rtc(tick_rtc),
        .dual_key(dual_key), .clr_stb(clr_stb), .clr_a(clr_a), .clr_b(clr_b),
        .halted(halted), .halt_enter(halt_enter),
        .chip_rst(chip_rst), .wake(wake), .to_flag(to_flag),
        .pdf_flag(pdf_flag), .wd_count(wd_count)
    );

    // {sel[1:0], tick mask {rtc,instr,local}, strobes[7:0], expected count[7:0]}
    localparam int NV = 6;
    localparam logic [20:0] VEC [NV] = '{
        {2'd1, 3'b001, 8'd16, 8'd2},
        {2'd1, 3'b110, 8'd16, 8'd0},
        {2'd2, 3'b010, 8'd24, 8'd3},
        {2'd3, 3'b100, 8'd8,  8'd1},
        {2'd0, 3'b111, 8'd16, 8'd0},
        {2'd3, 3'b011, 8'd8,  8'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic ticks(input int n, input logic [2:0] mask);
        for (int i = 0; i < n; i++) begin
            {tick_rtc, tick_instr, tick_local} = mask;
            cyc();
        end
        {tick_rtc, tick_instr, tick_local} = 3'b000;
    endtask

    task automatic single_clear();
        clr_stb = 1; cyc(); clr_stb = 0;
    endtask

    task automatic key(input bit b);
        if (b) clr_b = 1; else clr_a = 1;
        cyc();
        clr_a = 0; clr_b = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        // R1 reset state
        chk("R1 count", wd_count, 0);
        chk("R1 flags", {to_flag, pdf_flag, chip_rst, wake}, 0);
        rst_n = 1;
        cyc();

        // R2/R3 table of source-select patterns
        for (int v = 0; v < NV; v++) begin
            single_clear();
            src_sel = VEC[v][20:19];
            ticks(int'(VEC[v][15:8]), VEC[v][18:16]);
            chk($sformatf("R2/R3 vector %0d", v), wd_count, int'(VEC[v][7:0]));
        end

        // R4 time-out while running
        single_clear();
        src_sel = 2'd2;
        ticks(2047, 3'b010);
        chk("R4 no reset before limit", chip_rst, 0);
        chk("R4 count at top", wd_count, 255);
        ticks(1, 3'b010);
        chk("R4 reset pulse", chip_rst, 1);
        chk("R4 to_flag", to_flag, 1);
        chk("R4 count wrapped", wd_count, 0);
        chk("R4 no wake", wake, 0);
        cyc();
        chk("R4 single-cycle reset", chip_rst, 0);

        // R6 clear drops to_flag
        single_clear();
        chk("R6 to cleared", to_flag, 0);

        // R10 pdf set, R5 time-out while halted
        halted = 1; halt_enter = 1; cyc(); halt_enter = 0;
        chk("R10 pdf set", pdf_flag, 1);
        ticks(2048, 3'b010);
        chk("R5 wake pulse", wake, 1);
        chk("R5 no reset", chip_rst, 0);
        chk("R5 to set", to_flag, 1);
        chk("R5 pdf kept", pdf_flag, 1);
        cyc();
        chk("R5 wake single", wake, 0);
        halted = 0;
        single_clear();
        chk("R6 pdf cleared", pdf_flag, 0);

        // R10 clear wins over halt_enter
        halt_enter = 1; clr_stb = 1; cyc(); halt_enter = 0; clr_stb = 0;
        chk("R10 clear priority", pdf_flag, 0);

        // R11 clear with tick at limit
        ticks(2047, 3'b010);
        clr_stb = 1; tick_instr = 1; cyc(); clr_stb = 0; tick_instr = 0;
        chk("R11 count zero", wd_count, 0);
        chk("R11 no reset", chip_rst, 0);
        ticks(7, 3'b010);
        chk("R11 prescaler restarted", wd_count, 0);
        ticks(1, 3'b010);
        chk("R11 eight strobes", wd_count, 1);

        // R6 keys ignored in single mode
        ticks(8, 3'b010);
        key(0); key(1);
        chk("R6 keys ignored", wd_count, 2);

        // R7/R8 two-key mode
        dual_key = 1;
        cyc();
        single_clear();
        chk("R7 general strobe ignored", wd_count, 2);
        key(0);
        chk("R7 lone key A", wd_count, 2);
        key(0);
        chk("R8 repeat A", wd_count, 2);
        key(1);
        chk("R7 A then B clears", wd_count, 0);
        ticks(8, 3'b010);
        key(1); key(1);
        chk("R8 repeat B", wd_count, 1);
        key(0);
        chk("R7 B then A clears", wd_count, 0);

        // R9 history forgotten after clear
        ticks(8, 3'b010);
        key(0); key(1);
        chk("R9 pair clears", wd_count, 0);
        ticks(8, 3'b010);
        key(0);
        chk("R9 lone key after clear", wd_count, 1);
        key(1);
        chk("R9 new pair clears", wd_count, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule